// File: doc/BRIEF.md
# Tiny Coherent Line Buffer with MEI Ownership

This block is a very small, fully associative store of cache lines that sits beside a datapath. It answers a fixed group of load and store operations with a combinational hit. A load that hits gets its word back in the cycle it is presented. Every line is either Invalid, Exclusive (clean, owned) or Modified (dirty, owned). A line is never held in a shared state, so the block never has to snoop on its own.

All coherence traffic goes through the backing L1. On a miss the block picks a slot and writes back a Modified victim. It then checks the missing line out of the L1 with exclusive ownership and replays the held request against the filled line. When the L1 asks for a line back with a shootdown, the block drops a clean copy at once. A dirty copy is written back first and then dropped. The datapath sees `dp_ready` low for as long as any of this is in progress.

Top module: `tiny_mei_cache`

## Requirements
- R1: `NUM_LINES` may be 1 to 4. Any line address may occupy any slot, and after reset every slot is Invalid, so no request is ready and no channel is active.
- R2: A load whose line is present has `dp_ready` high, and `dp_rdata` carries the addressed word in that same cycle.
- R3: A store whose line is present completes in its first cycle, replaces only the addressed word, and makes the line Modified.
- R4: A miss holds `dp_ready` low and raises `co_req_valid`, with the line address (`dp_addr` above bit 5) held stable until `co_req_ready`. After `co_resp_valid` the line is Exclusive. With an immediate grant and a response one cycle later, a load miss is accepted on its fourth cycle.
- R5: A store that misses allocates the line through a checkout and then merges its word, so the line ends Modified.
- R6: A shootdown of an Exclusive line is acknowledged in the cycle it is seen, with no writeback, and the line is gone afterwards.
- R7: A shootdown of a Modified line first drives the whole line on the writeback channel, held until `wb_ready`. `sd_ack` rises in the cycle the writeback is accepted, and the L1 then holds the stored data.
- R8: A shootdown of a line that is not present is acknowledged in the cycle it is seen, without a writeback.
- R9: The fill slot is the lowest-numbered Invalid slot. When every slot is valid, a round-robin pointer starting at slot 0 picks the victim and advances by one. A Modified victim's writeback is accepted before the checkout request appears.
- R10: A shootdown that arrives while a checkout is outstanding is not acknowledged until the checkout response has been taken.
- R11: `dp_ready` is low while a writeback or checkout is in progress and while `sd_req` is pending.
- R12: Lines are 32 bytes of eight 32-bit words. Word n occupies line bits [32n+31:32n] and is selected by address bits [4:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_valid | input | 1 | Datapath request present, held until accepted |
| dp_write | input | 1 | Request is a store |
| dp_addr | input | ADDR_W | Byte address |
| dp_wdata | input | WORD_W | Store data |
| dp_ready | output | 1 | Request accepted this cycle (hit, nothing pending) |
| dp_rdata | output | WORD_W | Load word, valid with dp_ready |
| co_req_valid | output | 1 | Checkout request to the L1 |
| co_req_ready | input | 1 | L1 takes the checkout request |
| co_req_line | output | ADDR_W-5 | Line address being checked out |
| co_resp_valid | input | 1 | Checkout data returned with exclusive ownership |
| co_resp_data | input | 256 | Returned line, word 0 in the low bits |
| wb_valid | output | 1 | Dirty line being written back |
| wb_ready | input | 1 | L1 takes the writeback |
| wb_line | output | ADDR_W-5 | Line address of the writeback |
| wb_data | output | 256 | Line data of the writeback |
| sd_req | input | 1 | L1 requests removal of a line, held until acknowledged |
| sd_line | input | ADDR_W-5 | Line address to remove |
| sd_ack | output | 1 | Removal done this cycle |

## Verification
The bench plays the L1 and tracks the value every word should hold. It goes after a store miss whose word must survive the fill: a design that overwrote it with the checkout data would write stale data back on the next shootdown. It fills every slot and checks that the round-robin victim order and the writeback-before-checkout order hold. A wrong pointer shows up as an unexpected miss on a line that should still hit. A shootdown is raised during a slow checkout, and an early acknowledgement would leave a stale owned copy. A shootdown is also raised while a hit waits, where a design that ignored it would let the hit slip past the writeback.

// File: rtl/mei_cachelet_pkg.sv
package mei_cachelet_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_EXC = 2'd1,
      LS_MOD = 2'd2
   } line_state_e;

   typedef enum logic [2:0] {
      F_IDLE     = 3'd0,
      F_EVICT_WB = 3'd1,
      F_CO_REQ   = 3'd2,
      F_CO_WAIT  = 3'd3,
      F_SD_WB    = 3'd4
   } ctl_state_e;
endpackage

// File: rtl/cachelet_tag_match.sv
module cachelet_tag_match #(
   parameter int N  = 4,
   parameter int AW = 27,
   parameter int IW = 2
) (
   input  logic [N-1:0][AW-1:0] tags,
   input  logic [N-1:0]         valid,
   input  logic [AW-1:0]        probe,
   output logic                 hit,
   output logic [IW-1:0]        idx
);
   logic [N-1:0] match;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = valid[g] && (tags[g] == probe);
   end

   assign hit = |match;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (match[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/cachelet_victim_pick.sv
module cachelet_victim_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  valid,
   input  logic          advance,
   output logic [IW-1:0] victim
);
   if (N == 1) begin : g_single
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ valid[0] ^ advance;
      assign victim    = '0;
   end else begin : g_multi
      logic [IW-1:0] rr_q;
      logic [IW-1:0] first_inv;
      logic          all_valid;

      assign all_valid = &valid;

      always_comb begin
         first_inv = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) first_inv = IW'(i);
         end
      end

      assign victim = all_valid ? rr_q : first_inv;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rr_q <= '0;
         end else if (advance && all_valid) begin
            rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cachelet_line_store.sv
module cachelet_line_store #(
   parameter int N     = 4,
   parameter int IW    = 2,
   parameter int WORDS = 8,
   parameter int WW    = 32,
   parameter int OW    = 3
) (
   input  logic                clk,
   input  logic                fill_en,
   input  logic [IW-1:0]       fill_idx,
   input  logic [WORDS*WW-1:0] fill_data,
   input  logic                st_en,
   input  logic [IW-1:0]       st_idx,
   input  logic [OW-1:0]       st_word,
   input  logic [WW-1:0]       st_data,
   input  logic [IW-1:0]       rd_idx,
   input  logic [OW-1:0]       rd_word,
   output logic [WW-1:0]       rd_data,
   input  logic [IW-1:0]       wb_idx,
   output logic [WORDS*WW-1:0] wb_data
);
   localparam int LW = WORDS * WW;

   logic [LW-1:0] mem [N];

   for (genvar g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (fill_en && fill_idx == IW'(g)) begin
            mem[g] <= fill_data;
         end else if (st_en && st_idx == IW'(g)) begin
            for (int w = 0; w < WORDS; w++) begin
               if (st_word == OW'(w)) mem[g][w*WW +: WW] <= st_data;
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (rd_word == OW'(w)) rd_data = mem[rd_idx][w*WW +: WW];
      end
   end

   assign wb_data = mem[wb_idx];
endmodule

// File: rtl/tiny_mei_cache.sv
module tiny_mei_cache
   import mei_cachelet_pkg::*;
#(
   parameter int NUM_LINES  = 4,
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_BYTES = 32,
   localparam int BPW       = WORD_W / 8,
   localparam int WORDS     = LINE_BYTES / BPW,
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int BOFS_W    = (BPW > 1) ? $clog2(BPW) : 1,
   localparam int WOFS_W    = $clog2(WORDS),
   localparam int LOFS_W    = BOFS_W + WOFS_W,
   localparam int LA_W      = ADDR_W - LOFS_W,
   localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dp_valid,
   input  logic              dp_write,
   input  logic [ADDR_W-1:0] dp_addr,
   input  logic [WORD_W-1:0] dp_wdata,
   output logic              dp_ready,
   output logic [WORD_W-1:0] dp_rdata,
   output logic              co_req_valid,
   input  logic              co_req_ready,
   output logic [LA_W-1:0]   co_req_line,
   input  logic              co_resp_valid,
   input  logic [LINE_W-1:0] co_resp_data,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [LA_W-1:0]   wb_line,
   output logic [LINE_W-1:0] wb_data,
   input  logic              sd_req,
   input  logic [LA_W-1:0]   sd_line,
   output logic              sd_ack
);
   if (NUM_LINES < 1 || NUM_LINES > 4) begin : g_bad_lines
      $error("tiny_mei_cache: NUM_LINES must lie in 1..4");
   end
   if (WORD_W % 8 != 0 || WORD_W < 16) begin : g_bad_word
      $error("tiny_mei_cache: WORD_W must be a whole number of bytes, at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0 || LINE_BYTES % BPW != 0) begin : g_bad_line
      $error("tiny_mei_cache: a line must hold a power-of-two count of words, at least 2");
   end

   ctl_state_e               ctl;
   line_state_e              st [NUM_LINES];
   logic [NUM_LINES-1:0][LA_W-1:0] ltag;
   logic [NUM_LINES-1:0]     valid_vec;
   logic [NUM_LINES-1:0]     dirty_vec;
   logic [LA_W-1:0]          miss_line_q;
   logic [IDX_W-1:0]         vict_q;
   logic [IDX_W-1:0]         sd_idx_q;

   logic [LA_W-1:0]          dp_line;
   logic [WOFS_W-1:0]        dp_word;
   logic                     dp_hit;
   logic [IDX_W-1:0]         dp_idx;
   logic                     sd_hit;
   logic [IDX_W-1:0]         sd_idx;
   logic [IDX_W-1:0]         vict_idx;
   logic [IDX_W-1:0]         wb_idx;
   logic                     idle;
   logic                     start_miss;
   logic                     store_hit;
   logic                     fill_now;
   logic                     unused_byte_ofs;

   assign dp_line         = dp_addr[ADDR_W-1:LOFS_W];
   assign dp_word         = dp_addr[LOFS_W-1:BOFS_W];
   assign unused_byte_ofs = ^dp_addr[BOFS_W-1:0];

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_flags
      assign valid_vec[g] = (st[g] != LS_INV);
      assign dirty_vec[g] = (st[g] == LS_MOD);
   end

   cachelet_tag_match #(.N(NUM_LINES), .AW(LA_W), .IW(IDX_W)) u_dp_match (
      .tags(ltag), .valid(valid_vec), .probe(dp_line), .hit(dp_hit), .idx(dp_idx)
   );

   cachelet_tag_match #(.N(NUM_LINES), .AW(LA_W), .IW(IDX_W)) u_sd_match (
      .tags(ltag), .valid(valid_vec), .probe(sd_line), .hit(sd_hit), .idx(sd_idx)
   );

   assign idle       = (ctl == F_IDLE);
   assign dp_ready   = idle && !sd_req && dp_hit;
   assign start_miss = idle && !sd_req && dp_valid && !dp_hit;
   assign store_hit  = dp_valid && dp_ready && dp_write;
   assign fill_now   = (ctl == F_CO_WAIT) && co_resp_valid;

   cachelet_victim_pick #(.N(NUM_LINES), .IW(IDX_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .valid(valid_vec), .advance(start_miss), .victim(vict_idx)
   );

   assign wb_idx = (ctl == F_SD_WB) ? sd_idx_q : vict_q;

   cachelet_line_store #(
      .N(NUM_LINES), .IW(IDX_W), .WORDS(WORDS), .WW(WORD_W), .OW(WOFS_W)
   ) u_store (
      .clk(clk),
      .fill_en(fill_now), .fill_idx(vict_q), .fill_data(co_resp_data),
      .st_en(store_hit), .st_idx(dp_idx), .st_word(dp_word), .st_data(dp_wdata),
      .rd_idx(dp_idx), .rd_word(dp_word), .rd_data(dp_rdata),
      .wb_idx(wb_idx), .wb_data(wb_data)
   );

   assign co_req_valid = (ctl == F_CO_REQ);
   assign co_req_line  = miss_line_q;
   assign wb_valid     = (ctl == F_EVICT_WB) || (ctl == F_SD_WB);
   assign wb_line      = ltag[wb_idx];
   assign sd_ack       = (idle && sd_req && !(sd_hit && dirty_vec[sd_idx]))
                       || ((ctl == F_SD_WB) && wb_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl         <= F_IDLE;
         miss_line_q <= '0;
         vict_q      <= '0;
         sd_idx_q    <= '0;
         for (int i = 0; i < NUM_LINES; i++) begin
            st[i]   <= LS_INV;
            ltag[i] <= '0;
         end
      end else begin
         unique case (ctl)
            F_IDLE: begin
               if (sd_req) begin
                  if (sd_hit) begin
                     if (dirty_vec[sd_idx]) begin
                        sd_idx_q <= sd_idx;
                        ctl      <= F_SD_WB;
                     end else begin
                        st[sd_idx] <= LS_INV;
                     end
                  end
               end else if (start_miss) begin
                  miss_line_q <= dp_line;
                  vict_q      <= vict_idx;
                  ctl         <= dirty_vec[vict_idx] ? F_EVICT_WB : F_CO_REQ;
               end else if (store_hit) begin
                  st[dp_idx] <= LS_MOD;
               end
            end
            F_EVICT_WB: begin
               if (wb_ready) begin
                  st[vict_q] <= LS_INV;
                  ctl        <= F_CO_REQ;
               end
            end
            F_CO_REQ: begin
               if (co_req_ready) ctl <= F_CO_WAIT;
            end
            F_CO_WAIT: begin
               if (co_resp_valid) begin
                  st[vict_q]   <= LS_EXC;
                  ltag[vict_q] <= miss_line_q;
                  ctl          <= F_IDLE;
               end
            end
            F_SD_WB: begin
               if (wb_ready) begin
                  st[sd_idx_q] <= LS_INV;
                  ctl          <= F_IDLE;
               end
            end
            default: ctl <= F_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tiny_mei_cache_chk.sv
module tiny_mei_cache_chk #(
   parameter int LA_W = 27
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dp_ready,
   input logic            co_req_valid,
   input logic            co_req_ready,
   input logic [LA_W-1:0] co_req_line,
   input logic            wb_valid,
   input logic            wb_ready,
   input logic [LA_W-1:0] wb_line,
   input logic            sd_req,
   input logic            sd_ack
);
   assert_wb_blocks_dp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> !dp_ready);

   assert_co_blocks_dp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      co_req_valid |-> !dp_ready);

   assert_sd_blocks_dp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sd_req |-> !dp_ready);

   assert_co_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (co_req_valid && !co_req_ready) |=> (co_req_valid && $stable(co_req_line)));

   assert_wb_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_line)));

   assert_ack_with_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_ack && wb_valid) |-> wb_ready);

   assert_no_ack_in_checkout_R10: assert property (@(posedge clk) disable iff (!rst_n)
      co_req_valid |-> !sd_ack);

   assert_no_co_with_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(co_req_valid && wb_valid));
endmodule

bind tiny_mei_cache tiny_mei_cache_chk #(.LA_W(LA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dp_ready(dp_ready),
   .co_req_valid(co_req_valid), .co_req_ready(co_req_ready), .co_req_line(co_req_line),
   .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_line(wb_line),
   .sd_req(sd_req), .sd_ack(sd_ack)
);

// File: tb/sim_tiny_mei_cache.sv
`timescale 1ns/1ps
module sim_tiny_mei_cache;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         dp_valid, dp_write;
   logic [31:0]  dp_addr, dp_wdata;
   logic         dp_ready;
   logic [31:0]  dp_rdata;
   logic         co_req_valid, co_req_ready;
   logic [26:0]  co_req_line;
   logic         co_resp_valid;
   logic [255:0] co_resp_data;
   logic         wb_valid, wb_ready;
   logic [26:0]  wb_line;
   logic [255:0] wb_data;
   logic         sd_req;
   logic [26:0]  sd_line;
   logic         sd_ack;

   always #2.5 clk = ~clk;

   tiny_mei_cache u0 (.*);

   int total = 0;
   int bad = 0;
   logic [31:0] l1mem  [128];
   logic [31:0] golden [128];
   int resp_cnt = 0;
   int resp_delay = 1;
   int co_line_q = 0;
   logic rdy_seen, ack_seen, wbv_seen, co_seen, resp_seen;
   logic [31:0] rdata_seen;
   logic [7:0] log_k [64];
   int         log_l [64];
   int         log_n = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic add_log(input logic [7:0] k, input int l);
      if (log_n < 64) begin
         log_k[log_n] = k;
         log_l[log_n] = l;
         log_n++;
      end
   endtask

   function automatic int count_log(input logic [7:0] k, input int l);
      int n = 0;
      for (int i = 0; i < log_n; i++) if (log_k[i] == k && log_l[i] == l) n++;
      return n;
   endfunction

   // one cycle: called just after a falling edge with request inputs set
   task automatic tick();
      #1;
      co_resp_valid = (resp_cnt == 1);
      if (resp_cnt == 1)
         for (int w = 0; w < 8; w++) co_resp_data[w*32 +: 32] = l1mem[co_line_q*8 + w];
      co_req_ready = co_req_valid;
      wb_ready     = wb_valid;
      #0.5;
      rdy_seen   = dp_ready;
      rdata_seen = dp_rdata;
      ack_seen   = sd_ack;
      wbv_seen   = wb_valid;
      co_seen    = co_req_valid;
      resp_seen  = co_resp_valid;
      if (wb_valid) begin
         for (int w = 0; w < 8; w++) l1mem[int'(wb_line[3:0])*8 + w] = wb_data[w*32 +: 32];
         add_log("W", int'(wb_line[3:0]));
      end
      if (co_req_valid) add_log("C", int'(co_req_line[3:0]));
      @(posedge clk);
      if (resp_cnt > 0) resp_cnt--;
      if (co_seen) begin
         resp_cnt  = resp_delay;
         co_line_q = int'(co_req_line[3:0]);
      end
      @(negedge clk);
   endtask

   task automatic access(input bit wr, input int line, input int word, input logic [31:0] wd,
                         output logic [31:0] rd, output int stalls);
      dp_valid = 1'b1;
      dp_write = wr;
      dp_addr  = 32'(line * 32 + word * 4);
      dp_wdata = wd;
      stalls   = 0;
      rd       = '0;
      for (int k = 0; k < 100; k++) begin
         tick();
         if (rdy_seen) begin
            rd = rdata_seen;
            break;
         end
         stalls++;
      end
      dp_valid = 1'b0;
      dp_write = 1'b0;
      if (wr) golden[line*8 + word] = wd;
   endtask

   task automatic shoot(input int line, output int cyc, output bit wbseen);
      sd_req  = 1'b1;
      sd_line = 27'(line);
      cyc     = 0;
      wbseen  = 1'b0;
      for (int k = 0; k < 100; k++) begin
         tick();
         cyc++;
         if (wbv_seen) wbseen = 1'b1;
         if (ack_seen) break;
      end
      sd_req = 1'b0;
   endtask

   task automatic load_chk(input int line, input int word, input int exp_stall, input string req);
      logic [31:0] rd;
      int st;
      access(1'b0, line, word, '0, rd, st);
      check(rd == golden[line*8 + word], req, rd, golden[line*8 + word]);
      if (exp_stall >= 0) check(st == exp_stall, req, 32'(st), 32'(exp_stall));
   endtask

   function automatic bit line_matches(input int line);
      for (int w = 0; w < 8; w++) if (l1mem[line*8 + w] !== golden[line*8 + w]) return 1'b0;
      return 1'b1;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int st, cyc, n;
      bit wbs, got_resp;
      for (int i = 0; i < 128; i++) begin
         l1mem[i]  = 32'h5A00_0000 + 32'(i) * 32'h0001_0307;
         golden[i] = l1mem[i];
      end
      rst_n = 1'b0; dp_valid = 0; dp_write = 0; dp_addr = 0; dp_wdata = 0;
      co_req_ready = 0; co_resp_valid = 0; co_resp_data = '0; wb_ready = 0;
      sd_req = 0; sd_line = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check(!dp_ready && !co_req_valid && !wb_valid && !sd_ack, "R1 reset",
            {28'd0, dp_ready, co_req_valid, wb_valid, sd_ack}, 32'd0);
      @(negedge clk);

      // R8: shootdown of absent line
      shoot(3, cyc, wbs);
      check(cyc == 1 && !wbs, "R8 absent shootdown", 32'(cyc), 32'd1);

      // R4: load miss, four cycles, one checkout
      log_n = 0;
      load_chk(2, 3, 3, "R4 load miss");
      check(log_n == 1 && log_k[0] == "C" && log_l[0] == 2, "R4 checkout line", 32'(log_l[0]), 32'd2);
      // R2: hit same cycle
      load_chk(2, 6, 0, "R2 load hit");
      // R3 / R12: store hit merges one word
      access(1'b1, 2, 5, 32'hC0FF_EE05, rd, st);
      check(st == 0, "R3 store hit", 32'(st), 32'd0);
      load_chk(2, 5, 0, "R12 stored word");
      load_chk(2, 4, 0, "R12 neighbour word");
      // R7: dirty shootdown
      log_n = 0;
      shoot(2, cyc, wbs);
      check(cyc == 2 && wbs, "R7 dirty shootdown", 32'(cyc), 32'd2);
      check(line_matches(2), "R7 written back", l1mem[21], golden[21]);
      // R6: clean shootdown
      load_chk(2, 0, 3, "R6 refill");
      shoot(2, cyc, wbs);
      check(cyc == 1 && !wbs, "R6 clean shootdown", 32'(cyc), 32'd1);
      load_chk(2, 1, 3, "R6 line removed");
      shoot(2, cyc, wbs);
      // R5: store miss allocates and merges
      access(1'b1, 6, 1, 32'h0BAD_F00D, rd, st);
      check(st == 3, "R5 store miss", 32'(st), 32'd3);
      shoot(6, cyc, wbs);
      check(wbs && line_matches(6), "R5 merged word written back", l1mem[49], golden[49]);

      // R9: victim selection
      for (int l = 8; l < 12; l++) load_chk(l, 0, 3, "R9 fill empty slot");
      log_n = 0;
      load_chk(12, 0, 3, "R9 clean victim");
      check(count_log("W", 8) == 0, "R9 clean victim silent", 32'(log_n), 32'd1);
      for (int l = 9; l < 13; l++) load_chk(l, 2, 0, "R9 survivors hit");
      access(1'b1, 9, 7, 32'h9999_0007, rd, st);
      log_n = 0;
      load_chk(13, 0, 4, "R9 dirty victim");
      check(log_n == 2 && log_k[0] == "W" && log_l[0] == 9 && log_k[1] == "C" && log_l[1] == 13,
            "R9 writeback before checkout", 32'(log_l[0]), 32'd9);
      check(line_matches(9), "R9 victim data", l1mem[79], golden[79]);
      load_chk(8, 0, 3, "R9 next victim");
      load_chk(11, 0, 0, "R9 pointer order");
      load_chk(10, 0, 3, "R9 evicted line misses");

      // R11: pending shootdown stalls a hit
      access(1'b1, 13, 3, 32'h1313_0003, rd, st);
      dp_valid = 1'b1; dp_write = 1'b0; dp_addr = 32'(12 * 32);
      sd_req = 1'b1; sd_line = 27'd13;
      tick();
      check(!rdy_seen && !ack_seen, "R11 stall on shootdown", {31'd0, rdy_seen}, 32'd0);
      tick();
      check(ack_seen && wbv_seen, "R7 ack with writeback", {31'd0, ack_seen}, 32'd1);
      sd_req = 1'b0;
      tick();
      check(rdy_seen && rdata_seen == golden[96], "R11 hit after shootdown", rdata_seen, golden[96]);
      dp_valid = 1'b0;

      // R10: shootdown during slow checkout
      resp_delay = 3;
      log_n = 0;
      dp_valid = 1'b1; dp_write = 1'b0; dp_addr = 32'(14 * 32 + 8);
      tick();
      tick();
      sd_req = 1'b1; sd_line = 27'd14;
      n = 0; got_resp = 1'b0;
      for (int k = 0; k < 50; k++) begin
         tick();
         n++;
         if (ack_seen) break;
         if (resp_seen) got_resp = 1'b1;
      end
      sd_req = 1'b0;
      check(n == 4 && got_resp, "R10 ack after checkout", 32'(n), 32'd4);
      for (int k = 0; k < 50; k++) begin
         tick();
         if (rdy_seen) break;
      end
      dp_valid = 1'b0;
      check(rdy_seen && rdata_seen == golden[114], "R10 load data", rdata_seen, golden[114]);
      check(count_log("C", 14) == 2, "R10 line fetched again", 32'(count_log("C", 14)), 32'd2);
      resp_delay = 1;

      // random mix
      void'($urandom(32'd24681357));
      for (int i = 0; i < 400; i++) begin
         int r, l, w;
         r = int'($urandom % 10);
         l = int'($urandom % 8);
         w = int'($urandom % 8);
         resp_delay = 1 + int'($urandom % 3);
         if (r == 0) begin
            shoot(l, cyc, wbs);
            check(line_matches(l), "R7 random shootdown", l1mem[l*8], golden[l*8]);
         end else if (r < 5) begin
            access(1'b1, l, w, $urandom, rd, st);
         end else begin
            load_chk(l, w, -1, "R12 random load");
         end
      end
      resp_delay = 1;
      for (int l = 0; l < 16; l++) begin
         shoot(l, cyc, wbs);
         check(line_matches(l), "R7 final flush", l1mem[l*8], golden[l*8]);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule